// File: doc/BRIEF.md
# Burst-Granting DMA Channel Arbiter

This block decides which of several peripheral DMA channels may move data on a bus that it shares with the processor. Each channel keeps four one-bit settings: enable, request mask, high priority, and a setting that makes it ignore single requests. Each setting is written through its own pair of set and clear strobes, so software never has to do a read-modify-write. Each channel also holds a burst length, stored as a power of two. A software request register lets a channel be started without any peripheral line.

When the arbiter is idle it chooses one eligible channel and commits to it for a whole burst. It gives one transfer strobe for each item the bus accepts. It steps aside in every cycle where the processor holds the bus, and it raises a one-cycle done pulse on the channel's own bit when the last item of the burst moves. It arbitrates again only after that point. The data path, the address generation and the descriptor storage belong to the surrounding DMA engine. That engine uses `grant_ch` and `xfer_strobe` to move each item.

Top module: `chan_arb_top`

## Requirements
- R1: `xfer_strobe` is high exactly when a grant is held, `bus_ready` is high and `cpu_busy` is low. It is never high in a cycle where `cpu_busy` is high.
- R2: `cfg_sel` selects a register: 0 enable-set, 1 enable-clear, 2 mask-set, 3 mask-clear, 4 priority-set, 5 priority-clear, 6 burst-only-set, 7 burst-only-clear, 8 software request. Other values do nothing. On a `cfg_wr_en` cycle, a 1 in `cfg_data` bit i sets or clears channel i's bit. A 0 bit leaves that channel's bit unchanged. The new value takes effect at the next clock edge.
- R3: A peripheral request (`breq` or `sreq`) on a channel that is disabled or masked is never granted.
- R4: When both kinds are eligible, a channel with its priority bit set wins over every channel with the bit clear.
- R5: Among eligible channels of the same priority, the lowest channel index wins.
- R6: A burst is 2^k items. k is written per channel through `size_wr_en`/`size_ch`/`size_log2`, values above 10 are stored as 10, and k resets to 0.
- R7: Once a grant starts, `grant_ch` stays constant until the burst's last item. Requests that arrive meanwhile, even from a higher-priority channel, are considered only after that.
- R8: While `cpu_busy` or a low `bus_ready` stalls a burst, the grant stays on the same channel and the remaining item count is kept.
- R9: In the cycle after a burst's last strobe, `done_pulse` has exactly the bit of that channel set and `grant_valid` is low.
- R10: A software request bit stays pending until a burst of that channel completes. It makes the channel eligible even when masked, but never while the channel is disabled.
- R11: With a channel's burst-only bit set, its `sreq` line is ignored and only `breq` or a software request starts it.
- R12: After reset, `grant_valid`, `xfer_strobe` and `done_pulse` are low. All per-channel bits are 0 and all burst sizes are 1 item.
- R13: A channel that is eligible in an idle cycle is granted from the next cycle. At least one cycle without a grant separates two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| breq | input | NCH | Peripheral burst request lines, level |
| sreq | input | NCH | Peripheral single request lines, level |
| cpu_busy | input | 1 | Processor is using the bus this cycle |
| bus_ready | input | 1 | Bus accepts one item this cycle |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | NCH | Per-channel write bits |
| size_wr_en | input | 1 | Burst size write strobe |
| size_ch | input | CH_W | Channel whose size is written |
| size_log2 | input | 4 | Burst length exponent k |
| grant_valid | output | 1 | A burst is granted |
| grant_ch | output | CH_W | Granted channel index |
| xfer_strobe | output | 1 | One item moves this cycle |
| done_pulse | output | NCH | One-cycle burst completion per channel |

## Verification
The processor can take the bus in the same cycle that a higher-priority channel asks for service in the middle of another channel's burst. Both events then test the rule that a burst is never cut short or handed over. The bench raises `cpu_busy`, and in the same stalled window it writes a software request for a high-priority channel. It then checks at every stalled cycle that the grant stays on the original channel with no strobe. The scoreboard expects all remaining items of the first channel before a single item of the second, and expects the done pulses in that order.

// File: rtl/chan_arb_pkg.sv
// Shared constants and the configuration register selector encoding
// for the burst-granting channel arbiter.
package chan_arb_pkg;

    localparam int LOG2_MAX = 10;              // largest burst exponent
    localparam int LOG2_W   = 4;               // width of a stored exponent
    localparam int CNT_W    = LOG2_MAX + 1;    // width of the item counter

    typedef enum logic [3:0] {
        SEL_EN_SET  = 4'd0,
        SEL_EN_CLR  = 4'd1,
        SEL_MSK_SET = 4'd2,
        SEL_MSK_CLR = 4'd3,
        SEL_PRI_SET = 4'd4,
        SEL_PRI_CLR = 4'd5,
        SEL_UB_SET  = 4'd6,
        SEL_UB_CLR  = 4'd7,
        SEL_SWREQ   = 4'd8
    } cfg_sel_e;

endpackage

// File: rtl/chan_cfg_regs.sv
// Per-channel configuration state: enable, mask, priority, burst-only,
// pending software requests and burst exponents.
// Assumes a single write per cycle; undefined selector codes are ignored.
module chan_cfg_regs
    import chan_arb_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [3:0]                    wr_sel,
    input  logic [NCH-1:0]                wr_data,
    input  logic                          sz_wr,
    input  logic [CH_W-1:0]               sz_ch,
    input  logic [LOG2_W-1:0]             sz_log2,
    input  logic [NCH-1:0]                sw_done,
    output logic [NCH-1:0]                en_q,
    output logic [NCH-1:0]                msk_q,
    output logic [NCH-1:0]                pri_q,
    output logic [NCH-1:0]                ub_q,
    output logic [NCH-1:0]                swp_q,
    output logic [NCH-1:0][LOG2_W-1:0]    size_q
);

    logic [LOG2_W-1:0] sz_clamped;
    logic [NCH-1:0]    sw_set;

    // Limit a written exponent to the largest supported burst.
    always_comb begin
        sz_clamped = (sz_log2 > LOG2_W'(LOG2_MAX)) ? LOG2_W'(LOG2_MAX) : sz_log2;
    end

    // Software request bits raised by this cycle's write.
    always_comb begin
        sw_set = (wr_en && (wr_sel == SEL_SWREQ)) ? wr_data : '0;
    end

    // Apply write-one-to-set / write-one-to-clear updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            msk_q <= '0;
            pri_q <= '0;
            ub_q  <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_EN_SET:  en_q  <= en_q  |  wr_data;
                SEL_EN_CLR:  en_q  <= en_q  & ~wr_data;
                SEL_MSK_SET: msk_q <= msk_q |  wr_data;
                SEL_MSK_CLR: msk_q <= msk_q & ~wr_data;
                SEL_PRI_SET: pri_q <= pri_q |  wr_data;
                SEL_PRI_CLR: pri_q <= pri_q & ~wr_data;
                SEL_UB_SET:  ub_q  <= ub_q  |  wr_data;
                SEL_UB_CLR:  ub_q  <= ub_q  & ~wr_data;
                default:     ;
            endcase
        end
    end

    // Hold software requests until the channel's burst completes; a new write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swp_q <= '0;
        end else begin
            swp_q <= (swp_q & ~sw_done) | sw_set;
        end
    end

    // One exponent register per channel.
    for (genvar gi = 0; gi < NCH; gi++) begin : g_size
        // Store the clamped exponent when this channel is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_q[gi] <= '0;
            end else if (sz_wr && (sz_ch == CH_W'(gi))) begin
                size_q[gi] <= sz_clamped;
            end
        end
    end

endmodule

// File: rtl/chan_prio_pick.sv
// Combinational winner selection: high-priority pool first, otherwise
// every eligible channel; lowest index wins within the chosen pool.
module chan_prio_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  elig,
    input  logic [NCH-1:0]  pri,
    output logic            any,
    output logic [CH_W-1:0] win
);

    logic [NCH-1:0] hi_pool;
    logic [NCH-1:0] pool;

    // Choose the pool that competes this cycle.
    always_comb begin
        hi_pool = elig & pri;
        pool    = (|hi_pool) ? hi_pool : elig;
        any     = |elig;
    end

    // Find the lowest set index of the chosen pool.
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pool[i] && !found) begin
                win   = CH_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/chan_burst_ctrl.sv
// Burst sequencer: latches a winner when idle, counts items the bus
// accepts, yields to the processor, and pulses done after the last item.
// Assumes the winner inputs are meaningful only while any_req is high.
module chan_burst_ctrl
    import chan_arb_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [CH_W-1:0]   win,
    input  logic [LOG2_W-1:0] win_log2,
    input  logic              cpu_busy,
    input  logic              bus_ready,
    output logic              active,
    output logic [CH_W-1:0]   cur_ch,
    output logic              strobe,
    output logic [NCH-1:0]    done,
    output logic [NCH-1:0]    sw_done
);

    logic [CNT_W-1:0] left_q;
    logic             last_item;

    // An item moves only on a cycle the processor leaves free.
    always_comb begin
        strobe    = active && bus_ready && !cpu_busy;
        last_item = strobe && (left_q == '0);
    end

    // Tell the configuration block which software request is served.
    always_comb begin
        sw_done = '0;
        if (last_item) begin
            sw_done[cur_ch] = 1'b1;
        end
    end

    // Grant, count down and release the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cur_ch <= '0;
            left_q <= '0;
            done   <= '0;
        end else begin
            done <= '0;
            if (!active) begin
                if (any_req) begin
                    active <= 1'b1;
                    cur_ch <= win;
                    left_q <= (CNT_W'(1) << win_log2) - CNT_W'(1);
                end
            end else if (strobe) begin
                if (last_item) begin
                    active       <= 1'b0;
                    done[cur_ch] <= 1'b1;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/chan_arb_top.sv
// Top of the burst-granting DMA channel arbiter. Forms each channel's
// eligibility from requests and configuration, picks a winner and runs
// its burst. Assumes one bus item per cycle when bus_ready is high.
module chan_arb_top
    import chan_arb_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    breq,
    input  logic [NCH-1:0]    sreq,
    input  logic              cpu_busy,
    input  logic              bus_ready,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_sel,
    input  logic [NCH-1:0]    cfg_data,
    input  logic              size_wr_en,
    input  logic [CH_W-1:0]   size_ch,
    input  logic [3:0]        size_log2,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_ch,
    output logic              xfer_strobe,
    output logic [NCH-1:0]    done_pulse
);

    logic [NCH-1:0]             en, msk, pri, ub, swp, sw_done, elig;
    logic [NCH-1:0][LOG2_W-1:0] size_tab;
    logic                       any_req;
    logic [CH_W-1:0]            win;
    logic [LOG2_W-1:0]          win_log2;

    chan_cfg_regs #(.NCH(NCH), .CH_W(CH_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .sz_wr   (size_wr_en),
        .sz_ch   (size_ch),
        .sz_log2 (size_log2),
        .sw_done (sw_done),
        .en_q    (en),
        .msk_q   (msk),
        .pri_q   (pri),
        .ub_q    (ub),
        .swp_q   (swp),
        .size_q  (size_tab)
    );

    // A channel competes if enabled and either a software request is
    // pending or an unmasked peripheral line asks.
    always_comb begin
        elig = en & (swp | (~msk & (breq | (sreq & ~ub))));
    end

    chan_prio_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .elig (elig),
        .pri  (pri),
        .any  (any_req),
        .win  (win)
    );

    // Burst exponent of the current winner.
    always_comb begin
        win_log2 = size_tab[win];
    end

    chan_burst_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .win       (win),
        .win_log2  (win_log2),
        .cpu_busy  (cpu_busy),
        .bus_ready (bus_ready),
        .active    (grant_valid),
        .cur_ch    (grant_ch),
        .strobe    (xfer_strobe),
        .done      (done_pulse),
        .sw_done   (sw_done)
    );

endmodule

// File: rtl/chan_arb_checker.sv
// Protocol checker for chan_arb_top, attached by bind. Watches ports only.
module chan_arb_checker #(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_busy,
    input logic            bus_ready,
    input logic            grant_valid,
    input logic [CH_W-1:0] grant_ch,
    input logic            xfer_strobe,
    input logic [NCH-1:0]  done_pulse
);

    a_r1_idle_cycles_only: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |-> (!cpu_busy && bus_ready && grant_valid));

    a_r7_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> (!grant_valid || $stable(grant_ch)));

    a_r8_stall_keeps_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_strobe) |=> grant_valid);

    a_r9_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse));

    a_r9_done_after_item: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_pulse) |-> ($past(xfer_strobe) && !grant_valid &&
                           (done_pulse == (NCH'(1) << $past(grant_ch)))));

endmodule

bind chan_arb_top chan_arb_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_busy    (cpu_busy),
    .bus_ready   (bus_ready),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch),
    .xfer_strobe (xfer_strobe),
    .done_pulse  (done_pulse)
);

// File: tb/test_chan_arb_top.sv
// Scoreboard bench: tasks queue the expected channel of every item and
// every done pulse; a negedge monitor pops and compares them.
module test_chan_arb_top;

    localparam int NCH        = 8;
    localparam int CH_W       = 3;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  breq, sreq, cfg_data, done_pulse;
    logic            cpu_busy, bus_ready, cfg_wr_en, size_wr_en;
    logic [3:0]      cfg_sel, size_log2;
    logic [CH_W-1:0] size_ch, grant_ch;
    logic            grant_valid, xfer_strobe;

    int errs   = 0;
    int checks = 0;
    int exp_q[$];
    int done_q[$];

    chan_arb_top #(.NCH(NCH), .CH_W(CH_W)) i_chan_arb_top (
        .clk(clk), .rst_n(rst_n), .breq(breq), .sreq(sreq),
        .cpu_busy(cpu_busy), .bus_ready(bus_ready),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .size_wr_en(size_wr_en), .size_ch(size_ch), .size_log2(size_log2),
        .grant_valid(grant_valid), .grant_ch(grant_ch),
        .xfer_strobe(xfer_strobe), .done_pulse(done_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [3:0] sel, input logic [NCH-1:0] d);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_data = d;
        tick();
        cfg_wr_en = 1'b0; cfg_data = '0;
    endtask

    task automatic set_size(input int ch, input int k);
        size_wr_en = 1'b1; size_ch = CH_W'(ch); size_log2 = 4'(k);
        tick();
        size_wr_en = 1'b0;
    endtask

    task automatic expect_burst(input int ch, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(ch);
        done_q.push_back(ch);
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while ((exp_q.size() != 0 || done_q.size() != 0 || grant_valid) && t < 5000) begin
            tick();
            t++;
        end
        chk(t < 5000, tag, t, 5000);
    endtask

    task automatic wait_grant();
        int t = 0;
        while (!grant_valid && t < 100) begin
            tick();
            t++;
        end
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (grant_valid) seen = 1'b1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    // Monitor: compare every moved item and every done pulse with the queues.
    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            if (xfer_strobe) begin
                chk(!cpu_busy, "R1 strobe while processor busy", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected item", int'(grant_ch), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(int'(grant_ch) == e, "R5 item channel order", int'(grant_ch), e);
                end
            end
            if (|done_pulse) begin
                if (done_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", int'(done_pulse), 0);
                end else begin
                    e = done_q.pop_front();
                    chk(done_pulse == (NCH'(1) << e), "R9 done channel", int'(done_pulse), 1 << e);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; breq = '0; sreq = '0; cpu_busy = 1'b0; bus_ready = 1'b1;
        cfg_wr_en = 1'b0; cfg_sel = '0; cfg_data = '0;
        size_wr_en = 1'b0; size_ch = '0; size_log2 = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        chk(!grant_valid && !xfer_strobe && done_pulse == '0, "R12 idle after reset",
            int'(grant_valid), 0);

        // R3: disabled channel with a peripheral request stays idle
        breq[2] = 1'b1;
        quiet(4, "R3 disabled channel granted");
        cfg(4'd2, 8'h04);                      // mask ch2
        cfg(4'd0, 8'h04);                      // enable ch2
        quiet(4, "R3 masked channel granted");
        cfg(4'd3, 8'h00);                      // R2 zero bits change nothing
        quiet(4, "R2 zero write altered mask");
        expect_burst(2, 1);
        cfg(4'd3, 8'h04);                      // R2 clear mask of ch2
        wait_grant();
        chk(grant_valid && grant_ch == 3'd2, "R2 grant after mask clear", int'(grant_ch), 2);
        breq[2] = 1'b0;
        drain("R2 drain");
        cfg(4'd0, 8'hFF);

        // R5 and R6 default size: equal priority, lowest index first
        expect_burst(3, 1);
        expect_burst(5, 1);
        cfg(4'd8, 8'h28);
        drain("R5 drain");

        // R4: high priority beats a lower index
        cfg(4'd4, 8'h41);
        set_size(6, 2);
        set_size(1, 1);
        expect_burst(6, 4);
        expect_burst(1, 2);
        cfg(4'd8, 8'h42);
        drain("R4 drain");

        // R7: high-priority request mid-burst waits
        set_size(4, 3);
        expect_burst(4, 8);
        expect_burst(0, 1);
        cfg(4'd8, 8'h10);
        wait_grant();
        cfg(4'd8, 8'h01);
        chk(grant_ch == 3'd4, "R7 grant moved mid-burst", int'(grant_ch), 4);
        drain("R7 drain");

        // R8 with R1: processor stall plus a high-priority request together
        set_size(2, 2);
        expect_burst(2, 4);
        expect_burst(0, 1);
        cfg(4'd8, 8'h04);
        wait_grant();
        cpu_busy = 1'b1;
        cfg(4'd8, 8'h01);
        for (int i = 0; i < 3; i++) begin
            chk(grant_valid && grant_ch == 3'd2 && !xfer_strobe, "R8 stalled grant",
                int'(grant_ch), 2);
            tick();
        end
        cpu_busy = 1'b0;
        bus_ready = 1'b0;
        repeat (2) tick();
        chk(grant_valid && grant_ch == 3'd2, "R8 ready stall grant", int'(grant_ch), 2);
        bus_ready = 1'b1;
        drain("R8 drain");

        // R13 grant timing and R9 done timing, single item on ch0
        expect_burst(0, 1);
        cfg(4'd8, 8'h01);
        chk(!grant_valid, "R13 grant too early", int'(grant_valid), 0);
        tick();
        chk(grant_valid && grant_ch == 3'd0 && xfer_strobe, "R13 grant cycle",
            int'(grant_valid), 1);
        tick();
        chk(done_pulse == 8'h01 && !grant_valid, "R9 done cycle", int'(done_pulse), 1);
        drain("R13 drain");

        // R10: software request bypasses mask but not enable
        cfg(4'd2, 8'h08);
        expect_burst(3, 1);
        cfg(4'd8, 8'h08);
        drain("R10 masked drain");
        cfg(4'd1, 8'h08);
        cfg(4'd8, 8'h08);
        quiet(5, "R10 disabled channel granted");
        expect_burst(3, 1);
        cfg(4'd0, 8'h08);
        drain("R10 pending kept");
        cfg(4'd3, 8'h08);

        // R11: burst-only channel ignores single requests
        cfg(4'd6, 8'h20);
        sreq[5] = 1'b1;
        quiet(5, "R11 single request granted");
        expect_burst(5, 1);
        breq[5] = 1'b1;
        wait_grant();
        breq[5] = 1'b0;
        drain("R11 burst drain");
        quiet(4, "R11 single request after burst");
        expect_burst(5, 1);
        cfg(4'd7, 8'h20);
        wait_grant();
        sreq[5] = 1'b0;
        drain("R11 single drain");

        // R6: exponent above the limit is clamped to 1024 items
        set_size(7, 15);
        expect_burst(7, 1024);
        cfg(4'd8, 8'h80);
        drain("R6 clamp drain");
        chk(exp_q.size() == 0, "R6 items left", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule